// File: doc/BRIEF.md
# Indirect Jump Bus Sequencer

This block runs the bus side of a three-byte indirect jump for a small processor with an 8-bit data bus and a 16-bit address bus. After a start strobe it steps through six read cycles. It fetches the opcode and then the two pointer bytes that follow it. It re-reads the last operand address once and throws that data away. It then reads the two bytes of the jump target through the pointer.

The low pointer byte is held in its own half of a two-half input latch, so the following high-byte read cannot overwrite it. When the last read completes, the block loads the new program counter from the two target bytes and raises a one-cycle done pulse. A surrounding core drives the current program counter and the start strobe, serves each read from memory, and picks up the new program counter when the done pulse appears.

Top module: `ijmp_seq`

## Requirements
- R1: A start strobe seen while idle begins a sequence of exactly six consecutive cycles with `rdStb` high. `rdStb` is low again in the cycle after the sixth.
- R2: In cycle 1, `addrOut` equals the `pcIn` value sampled with the start strobe.
- R3: In cycle 2, `addrOut` is that PC plus 1, modulo 2^16. The byte read in this cycle is the pointer's low byte.
- R4: In cycle 3, `addrOut` is that PC plus 2, modulo 2^16. The byte read in this cycle is the pointer's high byte.
- R5: In cycle 4, `addrOut` repeats PC plus 2, and the byte read in this cycle has no effect on any later address or on `pcOut`.
- R6: In cycle 5, `addrOut` is the pointer, formed as {high byte, low byte}. The low byte survives the high-byte read unchanged.
- R7: In cycle 6, `addrOut` is the pointer plus 1, with the carry propagating across all 16 bits (0xFFFF wraps to 0x0000).
- R8: In the cycle after cycle 6, `pcOut` equals {byte read in cycle 6, byte read in cycle 5} and `donePulse` is high. `donePulse` is high for that single cycle only.
- R9: A start strobe received during cycles 1 to 6 is ignored: the address sequence and the result are unchanged.
- R10: Synchronous reset returns the block to idle. After reset `addrOut` is 0, `rdStb` is 0, `donePulse` is 0 and `pcOut` is 0. Whenever the block is idle, `addrOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startStb | input | 1 | Begin a jump sequence (honoured when idle) |
| pcIn | input | 16 | Address of the jump opcode |
| rdData | input | 8 | Read data returned for the current address |
| addrOut | output | 16 | Address bus |
| rdStb | output | 1 | Read strobe, high in each bus cycle |
| donePulse | output | 1 | One-cycle pulse when `pcOut` is updated |
| pcOut | output | 16 | New program counter |

## Verification
The embedded assertions check several properties on every cycle:
- the address bus is zero whenever no read is in progress;
- the pointer low half stays stable across the high-byte capture;
- the cycle-6 address is the cycle-5 address plus one;
- the done pulse lasts a single cycle and carries the assembled target;
- a busy sequencer never restarts.

Only the bench scenarios can show the following: the full address order against an independently computed expectation, that the repeated cycle-4 read really is discarded, wrap-around at the top of the address space, and reset in the middle of a sequence.

// File: rtl/ijmp_pkg.sv
package ijmp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_OPLO, ST_OPHI, ST_OPREP, ST_TGTLO, ST_TGTHI
  } seqState_t;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_BASE, SEL_BASE1, SEL_BASE2, SEL_PTR, SEL_PTR1
  } addrSel_t;

  typedef struct packed {
    addrSel_t selAddr;
    logic     loadBase;
    logic     capLo;
    logic     capHi;
    logic     capTgt;
    logic     loadPc;
  } seqCtrl_t;

endpackage

// File: rtl/ijmp_ctrl.sv
module ijmp_ctrl
  import ijmp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     startStb,
  output seqCtrl_t ctrl,
  output logic     rdStb
);

  seqState_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (startStb) state <= ST_OPC;
        ST_OPC:   state <= ST_OPLO;
        ST_OPLO:  state <= ST_OPHI;
        ST_OPHI:  state <= ST_OPREP;
        ST_OPREP: state <= ST_TGTLO;
        ST_TGTLO: state <= ST_TGTHI;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl = '{selAddr: SEL_ZERO, loadBase: 1'b0, capLo: 1'b0,
             capHi: 1'b0, capTgt: 1'b0, loadPc: 1'b0};
    rdStb = (state != ST_IDLE);
    unique case (state)
      ST_IDLE:  ctrl.loadBase = startStb;
      ST_OPC:   ctrl.selAddr = SEL_BASE;
      ST_OPLO:  begin ctrl.selAddr = SEL_BASE1; ctrl.capLo = 1'b1; end
      ST_OPHI:  begin ctrl.selAddr = SEL_BASE2; ctrl.capHi = 1'b1; end
      ST_OPREP: ctrl.selAddr = SEL_BASE2;
      ST_TGTLO: begin ctrl.selAddr = SEL_PTR; ctrl.capTgt = 1'b1; end
      default:  begin ctrl.selAddr = SEL_PTR1; ctrl.loadPc = 1'b1; end
    endcase
  end

  // R9: once busy, the sequence never jumps back to its first cycle
  assert_busy_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> (state != ST_OPC));

  // R1: the last bus cycle is always followed by an idle bus
  assert_six_then_idle_R1: assert property (@(posedge clk) disable iff (rst)
    ctrl.loadPc |=> !rdStb);

endmodule

// File: rtl/ijmp_datapath.sv
module ijmp_datapath
  import ijmp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  seqCtrl_t            ctrl,
  input  logic [2*DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0]   rdData,
  output logic [2*DATA_W-1:0] addrOut,
  output logic                donePulse,
  output logic [2*DATA_W-1:0] pcOut
);

  localparam int ADDR_W = 2 * DATA_W;

  logic [ADDR_W-1:0] pcBase;
  logic [DATA_W-1:0] ptrLo;   // input latch, low half
  logic [DATA_W-1:0] ptrHi;   // input latch, high half
  logic [DATA_W-1:0] tgtLo;
  logic [ADDR_W-1:0] ptrFull;

  assign ptrFull = {ptrHi, ptrLo};

  always_ff @(posedge clk) begin
    if (rst) begin
      pcBase    <= '0;
      ptrLo     <= '0;
      ptrHi     <= '0;
      tgtLo     <= '0;
      pcOut     <= '0;
      donePulse <= 1'b0;
    end else begin
      if (ctrl.loadBase) pcBase <= pcIn;
      if (ctrl.capLo)    ptrLo  <= rdData;
      if (ctrl.capHi)    ptrHi  <= rdData;
      if (ctrl.capTgt)   tgtLo  <= rdData;
      if (ctrl.loadPc)   pcOut  <= {rdData, tgtLo};
      donePulse <= ctrl.loadPc;
    end
  end

  always_comb begin
    unique case (ctrl.selAddr)
      SEL_BASE:  addrOut = pcBase;
      SEL_BASE1: addrOut = pcBase + ADDR_W'(1);
      SEL_BASE2: addrOut = pcBase + ADDR_W'(2);
      SEL_PTR:   addrOut = ptrFull;
      SEL_PTR1:  addrOut = ptrFull + ADDR_W'(1);
      default:   addrOut = '0;
    endcase
  end

  // R6: the high-byte capture leaves the low half untouched
  assert_ptr_lo_kept_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl.capHi |=> $stable(ptrLo));

  // R7: the second target address is the first plus one, full carry
  assert_ptr_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.selAddr == SEL_PTR) |=> (addrOut == $past(addrOut) + ADDR_W'(1)));

  // R8: done is a single-cycle pulse
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    donePulse |=> !donePulse);

  // R8: done carries the assembled target
  assert_done_target_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl.loadPc |=> (donePulse && pcOut == {$past(rdData), $past(tgtLo)}));

endmodule

// File: rtl/ijmp_seq.sv
module ijmp_seq
  import ijmp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                startStb,
  input  logic [2*DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0]   rdData,
  output logic [2*DATA_W-1:0] addrOut,
  output logic                rdStb,
  output logic                donePulse,
  output logic [2*DATA_W-1:0] pcOut
);

  seqCtrl_t ctrl;

  ijmp_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .startStb (startStb),
    .ctrl     (ctrl),
    .rdStb    (rdStb)
  );

  ijmp_datapath #(.DATA_W(DATA_W)) uPath (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .pcIn      (pcIn),
    .rdData    (rdData),
    .addrOut   (addrOut),
    .donePulse (donePulse),
    .pcOut     (pcOut)
  );

  // R10: the address bus rests at zero whenever no read is in progress
  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (rst)
    !rdStb |-> (addrOut == '0));

endmodule

// File: tb/tb_ijmp_seq.sv
module tb_ijmp_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startStb = 1'b0;
  logic [15:0] pcIn = '0;
  logic [7:0]  rdData = '0;
  logic [15:0] addrOut;
  logic        rdStb;
  logic        donePulse;
  logic [15:0] pcOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  ijmp_seq dut (
    .clk(clk), .rst(rst), .startStb(startStb), .pcIn(pcIn), .rdData(rdData),
    .addrOut(addrOut), .rdStb(rdStb), .donePulse(donePulse), .pcOut(pcOut)
  );

  typedef struct packed {
    logic [15:0] pc;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [7:0]  tl;
    logic [7:0]  th;
    logic [7:0]  junk;
    logic        inj;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{pc:16'h0200, lo:8'h34, hi:8'h12, tl:8'hCD, th:8'hAB, junk:8'h5A, inj:1'b0},
    '{pc:16'h8000, lo:8'hFF, hi:8'h12, tl:8'h11, th:8'h22, junk:8'hEE, inj:1'b1},
    '{pc:16'hFFFE, lo:8'hFF, hi:8'hFF, tl:8'h3C, th:8'hC3, junk:8'h00, inj:1'b0},
    '{pc:16'h1000, lo:8'h00, hi:8'h00, tl:8'h00, th:8'h80, junk:8'hFF, inj:1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // wait to the falling edge, where outputs are sampled and inputs changed
  task automatic toNeg();
    @(negedge clk);
  endtask

  task automatic runJump(input vec_t v);
    logic [15:0] ptr;
    ptr = {v.hi, v.lo};
    toNeg();
    pcIn = v.pc; startStb = 1'b1;
    toNeg();                                   // cycle 1
    startStb = v.inj; pcIn = ~v.pc;            // R9: strobe while busy
    chk("R1 rd c1", 16'(rdStb), 16'd1);
    chk("R2 addr c1", addrOut, v.pc);
    rdData = 8'hEA;
    toNeg();                                   // cycle 2
    chk("R1 rd c2", 16'(rdStb), 16'd1);
    chk("R3 addr c2", addrOut, v.pc + 16'd1);
    rdData = v.lo;
    toNeg();                                   // cycle 3
    chk("R1 rd c3", 16'(rdStb), 16'd1);
    chk("R4 addr c3", addrOut, v.pc + 16'd2);
    rdData = v.hi;
    toNeg();                                   // cycle 4
    chk("R1 rd c4", 16'(rdStb), 16'd1);
    chk("R5 addr c4", addrOut, v.pc + 16'd2);
    rdData = v.junk;
    toNeg();                                   // cycle 5
    chk("R1 rd c5", 16'(rdStb), 16'd1);
    chk("R6 R5 addr c5", addrOut, ptr);
    rdData = v.tl;
    toNeg();                                   // cycle 6
    chk("R1 rd c6", 16'(rdStb), 16'd1);
    chk("R7 addr c6", addrOut, ptr + 16'd1);
    rdData = v.th;
    startStb = 1'b0;
    toNeg();                                   // result cycle
    chk("R1 rd after", 16'(rdStb), 16'd0);
    chk("R10 idle addr", addrOut, 16'h0000);
    chk("R8 done", 16'(donePulse), 16'd1);
    chk("R8 pcOut", pcOut, {v.th, v.tl});
    toNeg();
    chk("R8 done single", 16'(donePulse), 16'd0);
    chk("R8 pcOut held", pcOut, {v.th, v.tl});
    chk("R9 no restart", 16'(rdStb), 16'd0);
  endtask

  initial begin
    #800000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    toNeg();
    rst = 1'b0;
    // R10: reset state
    chk("R10 reset addr", addrOut, 16'h0000);
    chk("R10 reset rd", 16'(rdStb), 16'd0);
    chk("R10 reset done", 16'(donePulse), 16'd0);
    chk("R10 reset pc", pcOut, 16'h0000);

    for (int i = 0; i < NV; i++) runJump(VECS[i]);

    // R10: reset in the middle of a sequence
    toNeg();
    pcIn = 16'h4444; startStb = 1'b1;
    toNeg(); startStb = 1'b0;
    toNeg();
    toNeg();
    rst = 1'b1;
    toNeg();
    chk("R10 mid rst addr", addrOut, 16'h0000);
    chk("R10 mid rst rd", 16'(rdStb), 16'd0);
    chk("R10 mid rst pc", pcOut, 16'h0000);
    rst = 1'b0;
    toNeg();
    toNeg();
    chk("R10 stays idle", 16'(rdStb), 16'd0);
    chk("R10 no done", 16'(donePulse), 16'd0);

    // sequence after reset runs normally
    runJump(VECS[0]);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule